// File: doc/BRIEF.md
# Four-Stage Load/Shift Register with JK-Controlled Entry Stage

This block is a small clocked register of four stages, named A (bit 0) through D (bit 3). Each rising clock edge does one of two things, chosen by a mode input. In load mode it captures a four-bit parallel word. In shift mode every stage passes its value one place toward stage D. In shift mode, stage A does not take a plain serial bit. It takes its next value from a J input and an active-low K input, so it can hold, clear, set or toggle.

An active-low clear empties all stages at once, with no clock needed. The outputs are the four stage values and a complemented copy of stage D. Typical uses are a loadable shift chain, or a chain whose first stage works as a toggle element, for example to build twisted-ring counters.

Top module: `jkq_shift_reg`

## Requirements
- R1: While `clr_n` is low, `q` reads 4'b0000 and `q_last_n` reads 1. This takes effect at once, without waiting for a clock edge.
- R2: Between rising edges of `clk`, `q` does not change, even when the other inputs change.
- R3: When `shift_en` is 0 at a rising edge, `q` takes the value of `par_d`. `j_in` and `k_n_in` have no effect on that edge.
- R4: When `shift_en` is 1 at a rising edge, `q[1]`, `q[2]` and `q[3]` take the old values of `q[0]`, `q[1]` and `q[2]`.
- R5: In shift mode with `j_in`=0 and `k_n_in`=1, `q[0]` keeps its old value.
- R6: In shift mode with `j_in`=0 and `k_n_in`=0, `q[0]` becomes 0.
- R7: In shift mode with `j_in`=1 and `k_n_in`=1, `q[0]` becomes 1.
- R8: In shift mode with `j_in`=1 and `k_n_in`=0, `q[0]` becomes the inverse of its old value.
- R9: `q_last_n` always equals the inverse of `q[3]`, including after a clear and after a load.
- R10: Clear overrides any clock edge that occurs while it is low. The first rising edge after clear is released acts according to `shift_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | Mode select: 0 = parallel load, 1 = shift |
| j_in | input | 1 | J input of the entry stage |
| k_n_in | input | 1 | Inverted K input of the entry stage |
| par_d | input | 4 | Parallel load word; bit 0 goes to stage A |
| q | output | 4 | Stage values; bit 0 is stage A, bit 3 is stage D |
| q_last_n | output | 1 | Complement of stage D |

## Verification
Two events can fall in the same clock period: an asynchronous clear and a rising clock edge that would load or shift. The bench provokes this in two ways. It drops clear for a short pulse between two edges at random points. It also holds clear low across a full edge while shift mode has J and K-bar set to force a 1. It then reads `q` during the clear and after the next edge. A correct design shows zeros while clear is low, ignores the edge that happened during clear, and on the first edge after release loads or shifts starting from an all-zero register.

// File: rtl/jkq_pkg.sv
package jkq_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ENTRY_KEEP   = 2'd0,
        ENTRY_ZERO   = 2'd1,
        ENTRY_ONE    = 2'd2,
        ENTRY_INVERT = 2'd3
    } entry_act_e;

endpackage

// File: rtl/jkq_entry_decode.sv
module jkq_entry_decode
    import jkq_pkg::*;
(
    input  logic       j_i,
    input  logic       k_n_i,
    input  logic       cur_i,
    output entry_act_e act_o,
    output logic       nxt_o
);

    always_comb begin
        unique case ({j_i, k_n_i})
            2'b01:   act_o = ENTRY_KEEP;
            2'b00:   act_o = ENTRY_ZERO;
            2'b11:   act_o = ENTRY_ONE;
            default: act_o = ENTRY_INVERT;
        endcase
    end

    always_comb begin
        unique case (act_o)
            ENTRY_KEEP:   nxt_o = cur_i;
            ENTRY_ZERO:   nxt_o = 1'b0;
            ENTRY_ONE:    nxt_o = 1'b1;
            default:      nxt_o = ~cur_i;
        endcase
    end

endmodule

// File: rtl/jkq_stage_mux.sv
module jkq_stage_mux
    import jkq_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  mode_e             mode_i,
    input  logic [STAGES-1:0] par_i,
    input  logic [STAGES-1:0] cur_i,
    input  logic              entry_i,
    output logic [STAGES-1:0] nxt_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shifted;

    assign shifted[0] = entry_i;

    for (genvar g = 1; g <= LAST; g++) begin : g_chain
        assign shifted[g] = cur_i[g-1];
    end

    for (genvar g = 0; g <= LAST; g++) begin : g_sel
        assign nxt_o[g] = (mode_i == MODE_SHIFT) ? shifted[g] : par_i[g];
    end

endmodule

// File: rtl/jkq_shift_reg.sv
module jkq_shift_reg
    import jkq_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_en,
    input  logic              j_in,
    input  logic              k_n_in,
    input  logic [STAGES-1:0] par_d,
    output logic [STAGES-1:0] q,
    output logic              q_last_n
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stages;
    } state_t;

    state_t     state_d;
    state_t     state_q;
    mode_e      mode;
    entry_act_e entry_act;
    logic       entry_nxt;
    logic [STAGES-1:0] mux_nxt;

    assign mode = mode_e'(shift_en);

    jkq_entry_decode u_entry (
        .j_i   (j_in),
        .k_n_i (k_n_in),
        .cur_i (state_q.stages[0]),
        .act_o (entry_act),
        .nxt_o (entry_nxt)
    );

    jkq_stage_mux #(.STAGES(STAGES)) u_mux (
        .mode_i  (mode),
        .par_i   (par_d),
        .cur_i   (state_q.stages),
        .entry_i (entry_nxt),
        .nxt_o   (mux_nxt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.stages = mux_nxt;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q        = state_q.stages;
    assign q_last_n = ~state_q.stages[LAST];

    // Checker state: set once an edge has passed with no clear since the previous edge.
    logic span_ok_q;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            span_ok_q <= 1'b0;
        end else begin
            span_ok_q <= 1'b1;
        end
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && !$past(shift_en)) |-> (q == $past(par_d)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && $past(shift_en)) |-> (q[LAST:1] == $past(q[LAST-1:0])));

    assert_keep_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && $past(shift_en) && !$past(j_in) && $past(k_n_in)) |-> $stable(q[0]));

    assert_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && $past(shift_en) && !$past(j_in) && !$past(k_n_in)) |-> (q[0] == 1'b0));

    assert_one_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && $past(shift_en) && $past(j_in) && $past(k_n_in)) |-> (q[0] == 1'b1));

    assert_invert_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (span_ok_q && $past(shift_en) && $past(j_in) && !$past(k_n_in)) |-> (q[0] != $past(q[0])));

endmodule

// File: tb/tb_jkq_shift_reg.sv
`timescale 1ns/1ps
module tb_jkq_shift_reg;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       shift_en;
    logic       j_in;
    logic       k_n_in;
    logic [3:0] par_d;
    logic [3:0] q;
    logic       q_last_n;

    int unsigned total = 0;
    int unsigned bad   = 0;
    bit          done  = 1'b0;
    logic [3:0]  model = 4'b0000;

    always #5 clk = ~clk;

    jkq_shift_reg dut (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .j_in     (j_in),
        .k_n_in   (k_n_in),
        .par_d    (par_d),
        .q        (q),
        .q_last_n (q_last_n)
    );

    function automatic logic [3:0] next_val(logic [3:0] cur, logic sh, logic j, logic kn,
                                            logic [3:0] d);
        logic a;
        if (!sh) return d;
        case ({j, kn})
            2'b01:   a = cur[0];
            2'b00:   a = 1'b0;
            2'b11:   a = 1'b1;
            default: a = ~cur[0];
        endcase
        return {cur[2:0], a};
    endfunction

    function automatic string req_of(logic sh, logic j, logic kn);
        if (!sh) return "R3";
        case ({j, kn})
            2'b01:   return "R4/R5";
            2'b00:   return "R4/R6";
            2'b11:   return "R4/R7";
            default: return "R4/R8";
        endcase
    endfunction

    task automatic check(string req, logic [3:0] exp);
        total++;
        if (q !== exp) begin
            bad++;
            $display("FAIL %s q actual=%b expected=%b", req, q, exp);
        end
        total++;
        if (q_last_n !== ~exp[3]) begin
            bad++;
            $display("FAIL R9 q_last_n actual=%b expected=%b", q_last_n, ~exp[3]);
        end
    endtask

    // Called at a falling edge: drive, confirm hold, take a rising edge, check.
    task automatic step(logic sh, logic j, logic kn, logic [3:0] d);
        shift_en = sh; j_in = j; k_n_in = kn; par_d = d;
        #1;
        check("R2", model);
        @(posedge clk);
        model = next_val(model, sh, j, kn, d);
        @(negedge clk);
        check(req_of(sh, j, kn), model);
    endtask

    task automatic clear_pulse();
        #1 clr_n = 1'b0;
        #1 check("R1", 4'b0000);
        model = 4'b0000;
        #1 clr_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clr_n = 1'b0; shift_en = 1'b0; j_in = 1'b0; k_n_in = 1'b1; par_d = 4'h0;
        repeat (2) @(negedge clk);
        check("R1", 4'b0000);
        clr_n = 1'b1;

        // Directed: load, then each entry action
        step(1'b0, 1'b1, 1'b0, 4'b1010);      // R3, serial ignored
        step(1'b1, 1'b0, 1'b1, 4'b0000);      // R5 keep 0
        step(1'b1, 1'b1, 1'b1, 4'b1111);      // R7 set
        step(1'b1, 1'b0, 1'b1, 4'b0000);      // R5 keep 1
        step(1'b1, 1'b1, 1'b0, 4'b0000);      // R8 toggle to 0
        step(1'b1, 1'b1, 1'b0, 4'b0000);      // R8 toggle to 1
        step(1'b1, 1'b0, 1'b0, 4'b1111);      // R6 zero
        step(1'b0, 1'b0, 1'b0, 4'b0111);      // R3 / R9 with D=0

        // R10: clear held across an edge in shift/set mode, then release
        shift_en = 1'b1; j_in = 1'b1; k_n_in = 1'b1;
        clr_n = 1'b0;
        #1 check("R1", 4'b0000);
        @(posedge clk);
        @(negedge clk);
        check("R10", 4'b0000);
        model = 4'b0000;
        clr_n = 1'b1;
        step(1'b1, 1'b1, 1'b1, 4'b0000);
        check("R10", 4'b0001);

        // Random sequence with clear pulses between edges
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[3], r[7:4]);
            if (r[12:8] == 5'd0) clear_pulse();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule